// File: doc/BRIEF.md
# Lockstep Comparison Enable with Multi-Bit Fault Hardening

This block decides when a dual-core lockstep comparator may raise a mismatch, and it holds that decision in a form that a single stuck-at fault cannot silence. After reset, the shadow core lags the main core by a fixed number of cycles. Until the lag has elapsed, the two output streams cannot yet be compared. A release counter covers that window. Once the window has passed, the block produces a 4-bit release code. That code is registered once into the comparison-enable register, which then qualifies a purely combinational compare of the shadow core outputs against the delayed main core outputs.

The enable is never a single bit. It takes one of two 4-bit codes that differ in every position. The compare is armed for every value except the exact disarm code, so a corrupted or invalid code fails safe towards checking. The release counter saturates and has no wrap. Its increment and step are constants. It is built from two redundant copies, one counting up and one counting down, and any disagreement between them is reported as an integrity error.

The core-output buses are plain level inputs sampled every cycle and carry no valid/ready handshake. The lockstep pipeline itself supplies aligned data each cycle, so there is no back-pressure to apply.

Top module: `lockstep_cmp_gate`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mismatch_o` is 0, `cnt_err_o` is 0 and `shadow_rel_o` carries the disarm code.
- R2: The arm code is 4'b0101 and the disarm code is 4'b1010; `shadow_rel_o` only ever shows one of these in fault-free operation.
- R3: `shadow_rel_o` switches from 4'b1010 to 4'b0101 on exactly the `OFFSET`-th rising clock edge after reset is released, and it stays there.
- R4: The comparison arms one cycle after `shadow_rel_o` turns to the arm code. With differing data, `mismatch_o` first reads 1 after edge `OFFSET`+1 and reads 0 after every earlier edge.
- R5: Once armed, `mismatch_o` is 1 in the same cycle that `shadow_i` differs from `main_dly_i` in any bit, and 0 whenever the two are equal.
- R6: Any enable-register value other than exactly 4'b1010 arms the compare. This covers the arm code with any single bit flipped and the invalid value 4'b0000. The exact value 4'b1010 keeps `mismatch_o` at 0 even for differing data.
- R7: The release counter saturates rather than wrapping, so `shadow_rel_o` is still 4'b0101 many cycles after the window has passed.
- R8: `cnt_err_o` is 0 in fault-free operation and is 1 while either redundant counter copy is corrupted so that the two copies no longer sum to the counter maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_dly_i | input | DATA_W | Main core outputs after the lockstep delay pipeline |
| shadow_i | input | DATA_W | Shadow core outputs |
| mismatch_o | output | 1 | Armed and the two output buses differ |
| cnt_err_o | output | 1 | Redundant release counter copies disagree |
| shadow_rel_o | output | 4 | Multi-bit release code (0101 arm, 1010 disarm) |

## Verification
The bench builds the block with `OFFSET` = 5 and `DATA_W` = 8. With these values the counter is 3 bits wide and its copies saturate at 7, above the release threshold of 4. This puts both the exact release edge and the saturated plateau within a few dozen cycles. The narrow data width lets a short vector table cover single-bit, multi-bit and all-bit differences as well as equal data. Faults are injected by forcing the enable register and each counter copy from the bench. This exercises every single-bit flip of the arm code, the invalid all-zero code and the exact disarm code.

// File: rtl/lockstep_gate_pkg.sv
package lockstep_gate_pkg;
  localparam int unsigned CodeW = 4;
  typedef logic [CodeW-1:0] gate_code_t;
  localparam gate_code_t GateArm    = 4'b0101;
  localparam gate_code_t GateDisarm = 4'b1010;
endpackage

// File: rtl/lockstep_code_reg.sv
// Multi-bit code register: one independent flop per bit so the encoding
// survives as separate storage elements.
module lockstep_code_reg
  import lockstep_gate_pkg::*;
#(
  parameter gate_code_t RESET_VAL = GateDisarm
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  gate_code_t d_i,
  output gate_code_t q_o
);
  for (genvar b = 0; b < CodeW; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b] <= RESET_VAL[b];
      else         q_o[b] <= d_i[b];
    end
  end
endmodule

// File: rtl/lockstep_rel_cnt.sv
// Saturating release counter with a redundant down-counting copy.
module lockstep_rel_cnt #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [WIDTH-1:0] cnt_o,
  output logic             err_o
);
  localparam logic [WIDTH-1:0] CntMax = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] Step   = WIDTH'(1);

  logic [WIDTH-1:0] up_q, up_d;
  logic [WIDTH-1:0] dn_q, dn_d;
  logic [WIDTH:0]   sum;

  always_comb begin
    up_d = (up_q == CntMax) ? up_q : up_q + Step;
    dn_d = (dn_q == '0)     ? dn_q : dn_q - Step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q <= '0;
      dn_q <= CntMax;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign sum   = {1'b0, up_q} + {1'b0, dn_q};
  assign err_o = (sum != {1'b0, CntMax});
  assign cnt_o = up_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni || err_o)
    (up_q == CntMax) |=> (up_q == CntMax)); // R7
  AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || err_o)
    (up_q != CntMax) |=> (up_q == $past(up_q) + Step)); // R3
  AST_DN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni || err_o)
    (dn_q != '0) |=> (dn_q == $past(dn_q) - Step)); // R8
endmodule

// File: rtl/lockstep_cmp_gate.sv
module lockstep_cmp_gate
  import lockstep_gate_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFFSET = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] main_dly_i,
  input  logic [DATA_W-1:0] shadow_i,
  output logic              mismatch_o,
  output logic              cnt_err_o,
  output logic [CodeW-1:0]  shadow_rel_o
);
  localparam int unsigned     CntW   = (OFFSET < 1) ? 1 : $clog2(OFFSET + 1);
  localparam logic [CntW-1:0] RelThr = CntW'(OFFSET - 1);

  logic [CntW-1:0] cnt;
  gate_code_t      set_d, set_q, en_q;

  lockstep_rel_cnt #(.WIDTH(CntW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .err_o (cnt_err_o)
  );

  // Greater-or-equal against a saturating count: no exact-match weak point.
  assign set_d = (cnt >= RelThr) ? GateArm : GateDisarm;

  lockstep_code_reg #(.RESET_VAL(GateDisarm)) u_set (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(set_d), .q_o(set_q)
  );

  lockstep_code_reg #(.RESET_VAL(GateDisarm)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(set_q), .q_o(en_q)
  );

  // Anything but the exact disarm code arms the compare (fail safe).
  assign mismatch_o   = (en_q != GateDisarm) && (shadow_i != main_dly_i);
  assign shadow_rel_o = set_q;

  AST_REL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni || cnt_err_o)
    (shadow_rel_o == GateArm) |=> (shadow_rel_o == GateArm)); // R3
  AST_REL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni || cnt_err_o)
    (shadow_rel_o == GateArm) || (shadow_rel_o == GateDisarm)); // R2
endmodule

// File: tb/lockstep_cmp_gate_tb_top.sv
module lockstep_cmp_gate_tb_top;
  localparam int unsigned DW  = 8;
  localparam int unsigned OFS = 5;
  localparam logic [3:0] ARM = 4'b0101;
  localparam logic [3:0] DIS = 4'b1010;

  // {main, shadow, expected mismatch}
  localparam int NV = 8;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0},
    {8'h00, 8'h01, 1'b1},
    {8'hA5, 8'hA5, 1'b0},
    {8'hA5, 8'h5A, 1'b1},
    {8'hFF, 8'h7F, 1'b1},
    {8'h3C, 8'h3C, 1'b0},
    {8'h00, 8'hFF, 1'b1},
    {8'h81, 8'h81, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] main_d = '0, shad = '0;
  logic          mis, err;
  logic [3:0]    rel;
  logic [3:0]    fval;
  int            n_chk = 0, n_bad = 0;
  logic          done = 1'b0;

  always #5 clk = ~clk;

  lockstep_cmp_gate #(.DATA_W(DW), .OFFSET(OFS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .main_dly_i(main_d), .shadow_i(shad),
    .mismatch_o(mis), .cnt_err_o(err), .shadow_rel_o(rel)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mismatch", {3'b0, mis}, 4'd0);
    chk("R1 err", {3'b0, err}, 4'd0);
    chk("R1 rel", rel, DIS);
    rst_n = 1'b1;
  endtask

  initial begin
    main_d = 8'h00; shad = 8'hFF;
    do_reset();
    // R3 / R4: exact release and arming edges with differing data
    for (int n = 1; n <= OFS + 3; n++) begin
      @(negedge clk);
      chk("R3 rel edge", rel, (n >= OFS) ? ARM : DIS);
      chk("R4 arm edge", {3'b0, mis}, (n >= OFS + 1) ? 4'd1 : 4'd0);
    end
    // R5: vector table while armed
    for (int i = 0; i < NV; i++) begin
      main_d = VEC[i][16:9]; shad = VEC[i][8:1];
      #2;
      chk("R5 compare", {3'b0, mis}, {3'b0, VEC[i][0]});
      @(negedge clk);
    end
    // R7: saturation, still released long after
    repeat (40) @(negedge clk);
    chk("R7 saturate", rel, ARM);
    chk("R8 quiet", {3'b0, err}, 4'd0);
    // R6: single-bit flips of the arm code keep comparison armed
    main_d = 8'h12; shad = 8'h13;
    for (int k = 0; k < 4; k++) begin
      fval = ARM ^ (4'b1 << k);
      force dut_i.en_q = fval;
      #2;
      chk("R6 flip armed", {3'b0, mis}, 4'd1);
      release dut_i.en_q;
      @(negedge clk);
    end
    fval = 4'b0000;
    force dut_i.en_q = fval;
    #2; chk("R6 invalid armed", {3'b0, mis}, 4'd1);
    fval = DIS;
    #2; chk("R6 disarm code", {3'b0, mis}, 4'd0);
    release dut_i.en_q;
    @(negedge clk);
    chk("R6 restored", {3'b0, mis}, 4'd1);
    // R8: corrupt each counter copy
    force dut_i.u_cnt.up_q = 3'd0;
    #2; chk("R8 up corrupt", {3'b0, err}, 4'd1);
    rst_n = 1'b0; #1;
    release dut_i.u_cnt.up_q;
    do_reset();
    repeat (10) @(negedge clk);
    force dut_i.u_cnt.dn_q = 3'd5;
    #2; chk("R8 dn corrupt", {3'b0, err}, 4'd1);
    rst_n = 1'b0; #1;
    release dut_i.u_cnt.dn_q;
    do_reset();
    @(negedge clk);
    chk("R8 cleared", {3'b0, err}, 4'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule